// File: doc/BRIEF.md
# Word-Serial AES Key Schedule Generator

This block turns a cipher key of 128, 192 or 256 bits into the complete list of 32-bit round-key words an AES datapath needs: 44, 52 or 60 words. After a start pulse it copies the key words into an internal word store. It then produces one new word per clock cycle until the schedule is complete, and raises a ready flag.

A cipher core reads the result as 128-bit round keys. It places a round number on a read index and gets back four consecutive words as one combinational value. One shared generator covers all three key lengths. It applies the rotate-substitute-constant step at the start of each key-length period. For 256-bit keys it also applies the substitute-only step at the middle of each period.

Top module: `aks_key_expander`

## Requirements
- R1: After reset, `ready` is low and `rd_key` is all zeros.
- R2: `key_len` selects the key size: 0 gives Nk=4 and Nr=10, 1 gives Nk=6 and Nr=12, 2 gives Nk=8 and Nr=14, and 3 behaves as 0. Key word j is taken from `key_in[255-32*j -: 32]`, so a shorter key sits in the upper bits. The unused lower bits have no effect.
- R3: Round key r, read with `rd_idx` = r for r in 0..Nr, is words 4r..4r+3 of the schedule. Word 4r is in bits [127:96] and word 4r+3 is in bits [31:0]. Words 0..Nk-1 are the key itself.
- R4: A word w[i] whose index is a multiple of Nk equals w[i-Nk] XOR SubWord(RotWord(w[i-1])) XOR a round constant in the top byte. RotWord moves the top byte to the bottom.
- R5: With Nk=8, a word w[i] with i mod 8 = 4 equals w[i-8] XOR SubWord(w[i-1]), with no rotation and no constant.
- R6: Every other word w[i] equals w[i-Nk] XOR w[i-1].
- R7: The round-constant byte is 01 on its first use after a start and is doubled in GF(2^8), modulo x^8+x^4+x^3+x+1, on each later use: 01, 02, 04 … 80, 1B, 36.
- R8: One word is written per cycle. `ready` is low from the cycle after the start edge. It rises exactly 4*(Nr+1)-Nk clock edges after the start edge (40, 46 or 52) and stays high until the next accepted start.
- R9: A start pulse while the schedule is still being generated is ignored, and the schedule finishes for the first key and size.
- R10: `rd_key` is all zeros while `ready` is low, and also when `rd_idx` is greater than Nr.
- R11: The schedule drives known-answer encryptions correctly: the 128-bit key 2B7E…4F3C takes 3243F6A8…0734 to 3925841D…0B32. Keys 000102… of 192 and 256 bits take 00112233…EEFF to DDA97CA4…7191 and 8EA2B7CA…6089.
- R12: A start after `ready` is high begins a new schedule, which may use a different key size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a new schedule when the block is not generating |
| key_len | input | 2 | Key-size select (0: 128, 1: 192, 2: 256, 3: 128) |
| key_in | input | 256 | Cipher key, word 0 in the top 32 bits |
| rd_idx | input | 4 | Round number to read |
| ready | output | 1 | Schedule is complete and readable |
| rd_key | output | 128 | Round key for `rd_idx`, or zeros |

## Verification
Assertions watch every cycle for several properties. The write index must advance by exactly one per generating cycle. The latched key size must not move during generation. `ready` must never be high together with generation, and must rise only out of it. The position counter within a key period must stay below Nk. The round constant must remain a legal doubling of 01, and the store must never be written out of range.

The values of the words can only be shown by the bench scenarios. These sweep every size select against an independent schedule model, using keys whose unused bits are garbage. The scenarios also show the exact latency to `ready`, zeros on out-of-range reads, a start ignored mid-run, and full known-answer encryptions built from the round keys read back.

// File: rtl/aks_pkg.sv
package aks_pkg;

   localparam int WORD_W = 32;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [1:0] {
      KLEN_128  = 2'd0,
      KLEN_192  = 2'd1,
      KLEN_256  = 2'd2,
      KLEN_RSVD = 2'd3
   } klen_e;

   // multiply by x in GF(2^8), reduction polynomial 0x11B
   function automatic logic [7:0] gf_xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = '0;
      sh  = a;
      for (int k = 0; k < 8; k++) begin
         if (b[k]) acc = acc ^ sh;
         sh = gf_xtime(sh);
      end
      return acc;
   endfunction

   // inverse as a^254 by square-and-multiply; zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] acc;
      logic [7:0] sq;
      acc = 8'h01;
      sq  = a;
      for (int k = 0; k < 7; k++) begin
         sq  = gf_mul(sq, sq);
         acc = gf_mul(acc, sq);
      end
      return acc;
   endfunction

   function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
      logic [7:0] b;
      b = gf_inv(a);
      return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
               ^ {b[3:0], b[7:4]} ^ 8'h63;
   endfunction

endpackage

// File: rtl/aks_subword.sv
module aks_subword #(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0] din,
   output logic [8*LANES-1:0] dout
);
   import aks_pkg::*;

   initial begin
      assert (LANES >= 1) else $error("aks_subword: LANES must be positive");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[8*g +: 8] = sbox_fwd(din[8*g +: 8]);
   end

endmodule

// File: rtl/aks_rcon.sv
module aks_rcon (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   input  logic       step,
   output logic [7:0] rcon
);
   import aks_pkg::*;

   logic [7:0] rcon_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rcon_q <= 8'h01;
      else if (init) rcon_q <= 8'h01;
      else if (step) rcon_q <= gf_xtime(rcon_q);
   end

   assign rcon = rcon_q;

   AST_RCON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(rcon_q) || rcon_q == 8'h1b || rcon_q == 8'h36 || rcon_q == 8'h6c); // R7

   AST_RCON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> rcon_q == 8'h01); // R7

endmodule

// File: rtl/aks_word_file.sv
module aks_word_file #(
   parameter int DEPTH  = 60,
   parameter int LOAD_W = 8,
   parameter int BLK_W  = 4,
   parameter int IDX_W  = 6,
   parameter int RIDX_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_en,
   input  logic [32*LOAD_W-1:0]  load_words,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [31:0]           wr_word,
   input  logic [IDX_W-1:0]      a_idx,
   input  logic [IDX_W-1:0]      b_idx,
   input  logic [RIDX_W-1:0]     blk_idx,
   output logic [31:0]           a_word,
   output logic [31:0]           b_word,
   output logic [32*BLK_W-1:0]   blk_words
);

   initial begin
      assert (LOAD_W <= DEPTH) else $error("aks_word_file: load wider than store");
      assert (DEPTH <= (1 << IDX_W)) else $error("aks_word_file: IDX_W too narrow");
   end

   logic [31:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) mem_q[d] <= '0;
      end else if (load_en) begin
         for (int k = 0; k < LOAD_W; k++)
            mem_q[k] <= load_words[32*(LOAD_W-1-k) +: 32];
      end else if (wr_en) begin
         mem_q[wr_idx] <= wr_word;
      end
   end

   assign a_word = (int'(a_idx) < DEPTH) ? mem_q[a_idx] : '0;
   assign b_word = (int'(b_idx) < DEPTH) ? mem_q[b_idx] : '0;

   for (genvar g = 0; g < BLK_W; g++) begin : g_blk
      int          lane_idx;
      logic [31:0] lane_w;
      always_comb begin
         lane_idx = int'(blk_idx) * BLK_W + g;
         lane_w   = (lane_idx < DEPTH) ? mem_q[lane_idx[IDX_W-1:0]] : '0;
      end
      assign blk_words[32*(BLK_W-1-g) +: 32] = lane_w;
   end

   AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> int'(wr_idx) < DEPTH); // R2

   AST_WRITE_ABOVE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> int'(wr_idx) >= 4); // R3

endmodule

// File: rtl/aks_key_expander.sv
module aks_key_expander #(
   parameter int MAX_NK = 8,
   parameter int MAX_NR = 14,
   parameter int RIDX_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [1:0]           key_len,
   input  logic [32*MAX_NK-1:0] key_in,
   input  logic [RIDX_W-1:0]    rd_idx,
   output logic                 ready,
   output logic [127:0]         rd_key
);
   import aks_pkg::*;

   localparam int MAX_WORDS = 4 * (MAX_NR + 1);
   localparam int IDX_W     = $clog2(MAX_WORDS);
   localparam int PH_W      = 4;

   initial begin
      assert (MAX_NK == 8) else $error("aks_key_expander: MAX_NK must be 8");
      assert (MAX_NR == 14) else $error("aks_key_expander: MAX_NR must be 14");
      assert ((MAX_NR + 1) <= (1 << RIDX_W)) else $error("aks_key_expander: RIDX_W too narrow");
   end

   // ---------------- size decode ----------------
   logic [PH_W-1:0]   cfg_nk;
   logic [RIDX_W-1:0] cfg_nr;
   logic [IDX_W-1:0]  cfg_last;

   always_comb begin
      unique case (key_len)
         KLEN_192: begin cfg_nk = PH_W'(6); cfg_nr = RIDX_W'(12); end
         KLEN_256: begin cfg_nk = PH_W'(8); cfg_nr = RIDX_W'(14); end
         default:  begin cfg_nk = PH_W'(4); cfg_nr = RIDX_W'(10); end
      endcase
      cfg_last = IDX_W'(4 * (int'(cfg_nr) + 1) - 1);
   end

   // ---------------- control state ----------------
   logic              busy_q;
   logic              ready_q;
   logic [IDX_W-1:0]  wr_idx_q;
   logic [PH_W-1:0]   phase_q;
   logic [PH_W-1:0]   nk_q;
   logic [RIDX_W-1:0] nr_q;
   logic [IDX_W-1:0]  last_q;

   logic launch;
   assign launch = start && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         ready_q  <= 1'b0;
         wr_idx_q <= '0;
         phase_q  <= '0;
         nk_q     <= PH_W'(4);
         nr_q     <= RIDX_W'(10);
         last_q   <= '0;
      end else if (launch) begin
         busy_q   <= 1'b1;
         ready_q  <= 1'b0;
         wr_idx_q <= IDX_W'(cfg_nk);
         phase_q  <= '0;
         nk_q     <= cfg_nk;
         nr_q     <= cfg_nr;
         last_q   <= cfg_last;
      end else if (busy_q) begin
         wr_idx_q <= wr_idx_q + IDX_W'(1);
         phase_q  <= (phase_q == nk_q - PH_W'(1)) ? '0 : phase_q + PH_W'(1);
         if (wr_idx_q == last_q) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b1;
         end
      end
   end

   // ---------------- word generator ----------------
   logic [IDX_W-1:0] prev_idx;
   logic [IDX_W-1:0] far_idx;
   word_t            prev_w;
   word_t            far_w;
   word_t            sub_in;
   word_t            sub_out;
   word_t            mix_w;
   word_t            new_w;
   logic [7:0]       rcon;
   logic             at_period;
   logic             at_half;

   assign prev_idx  = wr_idx_q - IDX_W'(1);
   assign far_idx   = wr_idx_q - IDX_W'(nk_q);
   assign at_period = (phase_q == '0);
   assign at_half   = (nk_q == PH_W'(8)) && (phase_q == PH_W'(4));
   assign sub_in    = at_period ? {prev_w[23:0], prev_w[31:24]} : prev_w;

   always_comb begin
      if (at_period)    mix_w = sub_out ^ {rcon, 24'h000000};
      else if (at_half) mix_w = sub_out;
      else              mix_w = prev_w;
   end

   assign new_w = far_w ^ mix_w;

   aks_subword #(.LANES(4)) u_sub (
      .din  (sub_in),
      .dout (sub_out)
   );

   aks_rcon u_rcon (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (launch),
      .step  (busy_q && at_period),
      .rcon  (rcon)
   );

   logic [127:0] blk;

   aks_word_file #(
      .DEPTH  (MAX_WORDS),
      .LOAD_W (MAX_NK),
      .BLK_W  (4),
      .IDX_W  (IDX_W),
      .RIDX_W (RIDX_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (launch),
      .load_words (key_in),
      .wr_en      (busy_q),
      .wr_idx     (wr_idx_q),
      .wr_word    (new_w),
      .a_idx      (prev_idx),
      .b_idx      (far_idx),
      .blk_idx    (rd_idx),
      .a_word     (prev_w),
      .b_word     (far_w),
      .blk_words  (blk)
   );

   assign ready  = ready_q;
   assign rd_key = (ready_q && rd_idx <= nr_q) ? blk : '0;

   // ---------------- assertions ----------------
   AST_READY_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> $past(busy_q)); // R8

   AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && ready_q)); // R8

   AST_ONE_WORD_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> wr_idx_q == $past(wr_idx_q) + IDX_W'(1)); // R8

   AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> $stable(nk_q) && $stable(last_q)); // R9

   AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> phase_q < nk_q); // R4

   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q && !start |=> ready_q); // R12

endmodule

// File: tb/aks_key_expander_test.sv
module aks_key_expander_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   key_len = 2'd0;
   logic [255:0] key_in = '0;
   logic [3:0]   rd_idx = '0;
   logic         ready;
   logic [127:0] rd_key;

   always #4 clk = ~clk;

   aks_key_expander uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .key_len (key_len),
      .key_in  (key_in),
      .rd_idx  (rd_idx),
      .ready   (ready),
      .rd_key  (rd_key)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0]   sb [256];
   logic [31:0]  ew [60];
   logic [127:0] rk [16];
   int           m_nk;
   int           m_nr;

   task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = '0;
      logic [7:0] x = a;
      logic [7:0] y = b;
      while (y != 0) begin
         if (y[0]) p = p ^ x;
         x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
         y = y >> 1;
      end
      return p;
   endfunction

   task automatic build_sbox();
      for (int v = 0; v < 256; v++) begin
         logic [7:0] inv = '0;
         logic [7:0] s;
         for (int y = 1; y < 256; y++)
            if (v != 0 && bmul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
         for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                 ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
         sb[v] = s;
      end
   endtask

   function automatic logic [31:0] subw(input logic [31:0] w);
      return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
   endfunction

   task automatic model_expand(input logic [255:0] key, input logic [1:0] len);
      logic [7:0]  rc = 8'h01;
      logic [31:0] t;
      m_nk = (len == 2'd1) ? 6 : (len == 2'd2) ? 8 : 4;
      m_nr = m_nk + 6;
      for (int i = 0; i < m_nk; i++) ew[i] = key[255-32*i -: 32];
      for (int i = m_nk; i < 4*(m_nr+1); i++) begin
         t = ew[i-1];
         if (i % m_nk == 0) begin
            t  = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
            rc = bmul(rc, 8'h02);
         end else if (m_nk == 8 && i % 8 == 4) begin
            t = subw(t);
         end
         ew[i] = ew[i-m_nk] ^ t;
      end
   endtask

   function automatic logic [127:0] encrypt(input logic [127:0] pt, input int nr);
      logic [7:0] s [16];
      logic [7:0] t [16];
      logic [127:0] o;
      for (int k = 0; k < 16; k++) s[k] = pt[127-8*k -: 8] ^ rk[0][127-8*k -: 8];
      for (int r = 1; r <= nr; r++) begin
         for (int k = 0; k < 16; k++) t[k] = sb[s[k]];
         for (int c = 0; c < 4; c++)
            for (int row = 0; row < 4; row++)
               s[row + 4*c] = t[row + 4*((c + row) % 4)];
         if (r != nr) begin
            for (int c = 0; c < 4; c++) begin
               logic [7:0] a0 = s[4*c], a1 = s[4*c+1], a2 = s[4*c+2], a3 = s[4*c+3];
               s[4*c]   = bmul(a0,8'h02) ^ bmul(a1,8'h03) ^ a2 ^ a3;
               s[4*c+1] = a0 ^ bmul(a1,8'h02) ^ bmul(a2,8'h03) ^ a3;
               s[4*c+2] = a0 ^ a1 ^ bmul(a2,8'h02) ^ bmul(a3,8'h03);
               s[4*c+3] = bmul(a0,8'h03) ^ a1 ^ a2 ^ bmul(a3,8'h02);
            end
         end
         for (int k = 0; k < 16; k++) s[k] = s[k] ^ rk[r][127-8*k -: 8];
      end
      for (int k = 0; k < 16; k++) o[127-8*k -: 8] = s[k];
      return o;
   endfunction

   // reads every index and compares with the model; fills rk
   task automatic read_back(input string tag);
      for (int r = 0; r < 16; r++) begin
         logic [127:0] exp;
         rd_idx = 4'(r);
         #1;
         exp = (r <= m_nr) ? {ew[4*r], ew[4*r+1], ew[4*r+2], ew[4*r+3]} : '0;
         if (r <= m_nr) chk({"R3/R4/R5/R6/R7 round key ", tag}, rd_key, exp);
         else           chk({"R10 index above Nr ", tag}, rd_key, exp);
         rk[r] = rd_key;
      end
   endtask

   // launch, measure latency, read back
   task automatic run_one(input logic [255:0] key, input logic [1:0] len, input string tag);
      int cnt = 0;
      model_expand(key, len);
      @(negedge clk);
      key_in = key; key_len = len; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      rd_idx = '0;
      chk({"R8 ready low after start ", tag}, {127'd0, ready}, 128'd0);
      chk({"R10 zero while not ready ", tag}, rd_key, 128'd0);
      while (!ready && cnt < 200) begin
         @(negedge clk);
         cnt++;
      end
      chk({"R8 latency ", tag}, 128'(cnt), 128'(4*(m_nr+1) - m_nk));
      read_back(tag);
   endtask

   function automatic logic [31:0] xs(input logic [31:0] x);
      logic [31:0] y = x;
      y = y ^ (y << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed = 32'h1234_abcd;
      logic [255:0] k;
      build_sbox();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ready at reset", {127'd0, ready}, 128'd0);
      chk("R1 rd_key at reset", rd_key, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset release", {127'd0, ready}, 128'd0);

      // R11: known answers for all three sizes
      run_one({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hdead_beef_0000_1111_2222_3333_4444_5555}, 2'd0, "kat128");
      chk("R11 encrypt 128", encrypt(128'h3243f6a8885a308d313198a2e0370734, 10),
          128'h3925841d02dc09fbdc118597196a0b32);
      run_one({192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'hffff_ffff_ffff_ffff}, 2'd1, "kat192");
      chk("R11 encrypt 192", encrypt(128'h00112233445566778899aabbccddeeff, 12),
          128'hdda97ca4864cdfe06eaf70a0ec0d7191);
      run_one(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 2'd2, "kat256");
      chk("R11 encrypt 256", encrypt(128'h00112233445566778899aabbccddeeff, 14),
          128'h8ea2b7ca516745bfeafc49904b496089);

      // R2/R12: sweep every size select with varied keys, restarting each time
      for (int len = 0; len < 4; len++) begin
         run_one('0, 2'(len), "zero key");
         run_one('1, 2'(len), "ones key");
         for (int n = 0; n < 5; n++) begin
            for (int w = 0; w < 8; w++) begin
               seed = xs(seed);
               k[32*w +: 32] = seed;
            end
            run_one(k, 2'(len), "sweep key");
         end
      end

      // R9: start during generation is ignored
      begin
         logic [255:0] ka = 256'hfeed_0001_0002_0003_0004_0005_0006_0007_0008_0009_000a_000b_000c_000d_000e_000f;
         int cnt = 0;
         model_expand(ka, 2'd2);
         @(negedge clk);
         key_in = ka; key_len = 2'd2; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (9) @(negedge clk);
         key_in = '1; key_len = 2'd0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         cnt = 10;
         while (!ready && cnt < 200) begin
            @(negedge clk);
            cnt++;
         end
         chk("R9 latency unchanged by mid-run start", 128'(cnt), 128'd52);
         read_back("R9 mid-run start");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule